// File: doc/BRIEF.md
# Interrupt Acknowledge Sequencer

This block sits between a processor core's interrupt inputs and its external bus. It watches a maskable request line and a non-maskable request line. At an instruction boundary it decides whether to take either of them. A taken non-maskable event produces a one-cycle strobe to the core. A taken maskable request becomes two consecutive locked acknowledge transactions on the bus. The vector byte returned by the second transaction is handed to the core together with a completion pulse.

A mode input picks where the two request lines come from. In legacy mode the two package pins drive the sequencer directly. In local-controller mode the pins are passed out as two local interrupt lines, and the sequencer takes its requests from the local controller's outputs instead. The bus is a request/ready pair. The request is held, and the transaction ends in the cycle where ready is sampled high.

Top module: `irq_ack_seq`

## Requirements
- R1: While reset is active, and in the first cycle after it, `bus_req`, `bus_lock`, `bus_second`, `ack_done` and `nmi_take` are all 0.
- R2: A maskable request starts a sequence only at a clock edge where `insn_boundary`=1, `if_flag`=1, the effective maskable line is 1 and no non-maskable event is pending. `bus_req` rises in the cycle after that edge.
- R3: If `insn_boundary` stays 0, no sequence starts, whatever the levels of the request lines and of `if_flag`.
- R4: A sequence consists of exactly two transactions. `bus_req` is held 1 throughout both. `bus_second`=0 marks the first transaction and `bus_second`=1 the second. Each transaction ends at the edge where `bus_rdy`=1, and the second transaction begins in the very next cycle.
- R5: `bus_lock` is 1 from the first cycle of the first transaction up to and including the ready edge of the second transaction. It is 0 in the cycle after that edge.
- R6: At the ready edge of the second transaction, bits [VEC_W-1:0] of `bus_vec_data` are captured. In the following cycle they appear on `ack_vector` while `ack_done`=1 for exactly one cycle. The data presented at the first ready has no effect.
- R7: The non-maskable line is edge-triggered. A 0-to-1 change marks one event as pending. Holding the line at 1 does not create a second event.
- R8: At a boundary edge with an event pending, `nmi_take` pulses for one cycle, the event is cleared, and no bus sequence starts at that edge, even if a maskable request is present.
- R9: With `lcl_mode`=0, `pin_intr` and `pin_nmi` are the request lines and `lint_out`=0. With `lcl_mode`=1, `ctl_intr` and `ctl_nmi` are the request lines, and `lint_out` = {`pin_nmi`, `pin_intr`}.
- R10: Boundary strobes that arrive while a sequence is in progress are ignored. After `ack_done`, a new sequence needs a new boundary.
- R11: A maskable request that drops before a boundary edge is lost, and no transaction occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lcl_mode | input | 1 | 1 = local-controller mode, 0 = legacy mode |
| pin_intr | input | 1 | Maskable request pin (local line 0 in local mode) |
| pin_nmi | input | 1 | Non-maskable request pin (local line 1 in local mode) |
| ctl_intr | input | 1 | Maskable request from the local controller |
| ctl_nmi | input | 1 | Non-maskable request from the local controller |
| lint_out | output | 2 | Pins forwarded to the local controller: bit 1 = nmi pin, bit 0 = intr pin |
| if_flag | input | 1 | Interrupt-enable flag from the core |
| insn_boundary | input | 1 | Instruction-completed strobe |
| bus_rdy | input | 1 | Bus ready; ends the current transaction |
| bus_vec_data | input | VEC_W | Low lanes of the read data bus |
| bus_req | output | 1 | Acknowledge transaction request |
| bus_lock | output | 1 | Bus lock |
| bus_second | output | 1 | 1 during the second acknowledge transaction |
| ack_done | output | 1 | One-cycle pulse with a valid vector |
| ack_vector | output | VEC_W | Captured interrupt vector |
| nmi_take | output | 1 | One-cycle pulse when a non-maskable event is taken |

## Verification
The assertions assume that `bus_rdy` is pulsed only while `bus_req` is high. They also assume that `lcl_mode` changes only while both non-maskable sources are low, because a switch between sources at different levels would look like an edge. The stimulus drives ready only inside a running sequence and changes the mode only with all request sources at 0. While a sequence runs, it keeps the maskable line high up to the first transaction.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACK1 = 2'd1,
        ST_ACK2 = 2'd2
    } ack_state_e;

    localparam int LINT_W = 2;
endpackage

// File: rtl/irq_pin_router.sv
module irq_pin_router
    import irq_ack_pkg::*;
(
    input  logic              lcl_mode,
    input  logic              pin_intr,
    input  logic              pin_nmi,
    input  logic              ctl_intr,
    input  logic              ctl_nmi,
    output logic              intr_eff,
    output logic              nmi_eff,
    output logic [LINT_W-1:0] lint_out
);
    always_comb begin
        if (lcl_mode) begin
            intr_eff = ctl_intr;
            nmi_eff  = ctl_nmi;
            lint_out = {pin_nmi, pin_intr};
        end else begin
            intr_eff = pin_intr;
            nmi_eff  = pin_nmi;
            lint_out = '0;
        end
    end
endmodule

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_src,
    input  logic nmi_clr,
    output logic nmi_pend
);
    typedef struct packed {
        logic prev;
        logic pend;
    } edge_regs_t;

    edge_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.prev = nmi_src;
        r_d.pend = (r_q.pend & ~nmi_clr) | (nmi_src & ~r_q.prev);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign nmi_pend = r_q.pend;

    // R7: a new pending event always follows a rising source
    assert_pend_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_pend) |-> ($past(nmi_src) && !$past(r_q.prev)));
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_ack_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             intr_lvl,
    input  logic             nmi_pend,
    input  logic             if_flag,
    input  logic             boundary,
    input  logic             bus_rdy,
    input  logic [VEC_W-1:0] bus_vec,
    output logic             nmi_clr,
    output logic             bus_req,
    output logic             bus_lock,
    output logic             bus_second,
    output logic             done,
    output logic [VEC_W-1:0] vec,
    output logic             nmi_go
);
    typedef struct packed {
        ack_state_e       st;
        logic             done;
        logic             nmi_go;
        logic [VEC_W-1:0] vec;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        r_d.nmi_go = 1'b0;
        nmi_clr    = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (boundary) begin
                    if (nmi_pend) begin
                        r_d.nmi_go = 1'b1;
                        nmi_clr    = 1'b1;
                    end else if (if_flag && intr_lvl) begin
                        r_d.st = ST_ACK1;
                    end
                end
            end
            ST_ACK1: begin
                if (bus_rdy) r_d.st = ST_ACK2;
            end
            ST_ACK2: begin
                if (bus_rdy) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.vec  = bus_vec;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, done: 1'b0, nmi_go: 1'b0, vec: '0};
        else        r_q <= r_d;
    end

    assign bus_req    = (r_q.st == ST_ACK1) || (r_q.st == ST_ACK2);
    assign bus_lock   = bus_req;
    assign bus_second = (r_q.st == ST_ACK2);
    assign done       = r_q.done;
    assign vec        = r_q.vec;
    assign nmi_go     = r_q.nmi_go;

    // R2: a sequence begins only from an enabled boundary with a request
    assert_start_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> ($past(boundary) && $past(if_flag) && $past(intr_lvl) && !$past(nmi_pend)));

    // R4: the second transaction comes only after a ready in the first
    assert_second_after_rdy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_second) |-> ($past(bus_req) && $past(bus_rdy)));

    // R6: completion follows the ready of the second transaction
    assert_done_after_second_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(bus_second) && $past(bus_rdy) && !bus_lock));

    // R8: taking a non-maskable event never starts bus traffic
    assert_nmi_no_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_go |-> (!bus_req && $past(nmi_pend)));
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
    import irq_ack_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lcl_mode,
    input  logic              pin_intr,
    input  logic              pin_nmi,
    input  logic              ctl_intr,
    input  logic              ctl_nmi,
    output logic [LINT_W-1:0] lint_out,
    input  logic              if_flag,
    input  logic              insn_boundary,
    input  logic              bus_rdy,
    input  logic [VEC_W-1:0]  bus_vec_data,
    output logic              bus_req,
    output logic              bus_lock,
    output logic              bus_second,
    output logic              ack_done,
    output logic [VEC_W-1:0]  ack_vector,
    output logic              nmi_take
);
    logic intr_eff, nmi_eff, nmi_pend, nmi_clr;

    irq_pin_router u_router (
        .lcl_mode (lcl_mode),
        .pin_intr (pin_intr),
        .pin_nmi  (pin_nmi),
        .ctl_intr (ctl_intr),
        .ctl_nmi  (ctl_nmi),
        .intr_eff (intr_eff),
        .nmi_eff  (nmi_eff),
        .lint_out (lint_out)
    );

    irq_nmi_edge u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi_src  (nmi_eff),
        .nmi_clr  (nmi_clr),
        .nmi_pend (nmi_pend)
    );

    irq_ack_fsm #(.VEC_W(VEC_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .intr_lvl   (intr_eff),
        .nmi_pend   (nmi_pend),
        .if_flag    (if_flag),
        .boundary   (insn_boundary),
        .bus_rdy    (bus_rdy),
        .bus_vec    (bus_vec_data),
        .nmi_clr    (nmi_clr),
        .bus_req    (bus_req),
        .bus_lock   (bus_lock),
        .bus_second (bus_second),
        .done       (ack_done),
        .vec        (ack_vector),
        .nmi_go     (nmi_take)
    );

    // R5: a request is never issued without the lock
    assert_req_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> bus_lock);
endmodule

// File: tb/irq_ack_seq_tb.sv
module irq_ack_seq_tb_top;
    localparam int VEC_W = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic lcl_mode, pin_intr, pin_nmi, ctl_intr, ctl_nmi;
    logic [1:0] lint_out;
    logic if_flag, insn_boundary, bus_rdy;
    logic [VEC_W-1:0] bus_vec_data;
    logic bus_req, bus_lock, bus_second, ack_done, nmi_take;
    logic [VEC_W-1:0] ack_vector;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    irq_ack_seq #(.VEC_W(VEC_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .lcl_mode(lcl_mode),
        .pin_intr(pin_intr), .pin_nmi(pin_nmi),
        .ctl_intr(ctl_intr), .ctl_nmi(ctl_nmi), .lint_out(lint_out),
        .if_flag(if_flag), .insn_boundary(insn_boundary),
        .bus_rdy(bus_rdy), .bus_vec_data(bus_vec_data),
        .bus_req(bus_req), .bus_lock(bus_lock), .bus_second(bus_second),
        .ack_done(ack_done), .ack_vector(ack_vector), .nmi_take(nmi_take)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear_inputs();
        pin_intr = 0; pin_nmi = 0; ctl_intr = 0; ctl_nmi = 0;
        insn_boundary = 0; bus_rdy = 0; bus_vec_data = '0;
    endtask

    // Called at the negedge just after the accepting edge
    task automatic run_seq(input logic [7:0] v, input int w1, input int w2);
        chk("R4", "req first", bus_req, 1);
        chk("R5", "lock first", bus_lock, 1);
        chk("R4", "second flag low", bus_second, 0);
        insn_boundary = 1;   // R10: boundaries inside the sequence are ignored
        for (int i = 0; i < w1; i++) begin
            step();
            chk("R4", "held first", {bus_req, bus_second, bus_lock}, 3'b101);
        end
        bus_rdy = 1; bus_vec_data = ~v;
        step();
        bus_rdy = 0;
        chk("R4", "second begins", {bus_req, bus_second}, 2'b11);
        chk("R5", "lock across", bus_lock, 1);
        chk("R6", "no early done", ack_done, 0);
        for (int i = 0; i < w2; i++) begin
            step();
            chk("R4", "held second", {bus_req, bus_second, bus_lock}, 3'b111);
        end
        bus_rdy = 1; bus_vec_data = v;
        step();
        bus_rdy = 0; insn_boundary = 0;
        chk("R5", "lock released", {bus_req, bus_lock}, 2'b00);
        chk("R6", "done pulse", ack_done, 1);
        chk("R6", "vector", ack_vector, v);
        step();
        chk("R6", "done one cycle", ack_done, 0);
        chk("R10", "no restart without boundary", bus_req, 0);
    endtask

    initial begin
        rst_n = 0; lcl_mode = 0; if_flag = 0;
        clear_inputs();
        pin_intr = 1; if_flag = 1; insn_boundary = 1;
        step(); step();
        chk("R1", "reset outputs", {bus_req, bus_lock, bus_second, ack_done, nmi_take}, 0);
        clear_inputs();
        rst_n = 1;
        step();
        chk("R1", "after reset", {bus_req, bus_lock, bus_second, ack_done, nmi_take}, 0);

        // R3: no boundary, no start
        pin_intr = 1; if_flag = 1;
        for (int i = 0; i < 5; i++) begin
            step();
            chk("R3", "no boundary", bus_req, 0);
        end
        // R11: request dropped before boundary
        pin_intr = 0; insn_boundary = 1;
        step();
        insn_boundary = 0;
        chk("R11", "dropped request lost", bus_req, 0);

        // R2/R9 sweep: mode x enable x level, with ready wait patterns
        for (int m = 0; m < 2; m++)
        for (int f = 0; f < 2; f++)
        for (int l = 0; l < 2; l++) begin
            clear_inputs();
            lcl_mode = m[0];
            step();
            if (m == 1) begin ctl_intr = l[0]; pin_intr = ~l[0]; end
            else        begin pin_intr = l[0]; ctl_intr = ~l[0]; end
            if_flag = f[0];
            #1;
            chk("R9", "lint_out", lint_out, (m == 1) ? {1'b0, pin_intr} : 2'b00);
            insn_boundary = 1;
            step();
            insn_boundary = 0;
            if (f == 1 && l == 1) begin
                for (int w = 0; w < 9; w++) begin
                    if (w > 0) begin
                        insn_boundary = 1;
                        step();
                        insn_boundary = 0;
                    end
                    run_seq(8'((w * 37 + m * 91 + 5) & 8'hFF), w % 3, w / 3);
                end
            end else begin
                chk("R2", "not accepted", bus_req, 0);
                step();
                chk("R2", "still idle", bus_req, 0);
            end
        end

        // R7/R8: NMI edge, priority and no retrigger
        clear_inputs();
        lcl_mode = 0; if_flag = 1;
        step();
        pin_nmi = 1; pin_intr = 1;
        step();
        insn_boundary = 1;
        step();
        insn_boundary = 0;
        chk("R8", "nmi taken", nmi_take, 1);
        chk("R8", "no bus on nmi", bus_req, 0);
        step();
        chk("R8", "nmi pulse one cycle", nmi_take, 0);
        insn_boundary = 1;
        step();
        insn_boundary = 0;
        chk("R7", "held level no retrigger", nmi_take, 0);
        chk("R7", "intr taken after nmi", bus_req, 1);
        run_seq(8'h5A, 1, 0);

        // R7/R9: local mode uses ctl_nmi, pin_nmi ignored
        clear_inputs();
        step();
        lcl_mode = 1;
        step();
        pin_nmi = 1;
        step();
        insn_boundary = 1;
        step();
        insn_boundary = 0;
        chk("R9", "pin nmi ignored in local mode", nmi_take, 0);
        chk("R9", "lint forwards nmi pin", lint_out, 2'b10);
        ctl_nmi = 1;
        step();
        insn_boundary = 1;
        step();
        insn_boundary = 0;
        chk("R9", "ctl nmi taken", nmi_take, 1);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule